// File: doc/BRIEF.md
# Serial Interrupt Line Peripheral Agent

This block is the peripheral end of a shared, single-wire serial interrupt line that runs on the bus clock. It follows every serial cycle on the line: a start pulse, a train of three-clock data frames, and a stop pulse. In the data frame assigned to each of its interrupt inputs it reports the registered level of that input. The line is pulled up externally. The agent drives it through an output-enable and an output value, so a pad can build an open-drain style tri-state driver from them.

After every stop pulse the agent measures how wide the pulse was, and this picks the mode of the next cycle. In continuous mode the agent stays passive and only answers cycles that the host starts. In quiet mode the agent starts a cycle on its own when an owned input changes and that change can no longer be reported in the cycle already running. To do this it pulls the line low for one clock, and the host then extends the pulse. The number of frames and the set of owned inputs are parameters.

Top module: `sirq_agent`

## Requirements
- R1: After reset the agent is in continuous mode with the output-enable low. In continuous mode it never drives the line outside its data-frame slots, whatever its inputs do.
- R2: Frame counting starts at the clock in which the line is first seen high after a start pulse (clock 0), whatever the pulse width (the host uses 4 to 8 clocks). The sample phase of frame N is at clock 3N-1, its recovery phase at clock 3N, and its turn-around phase at clock 3N+1.
- R3: In the sample phase of frame N, the agent drives low (output-enable 1, value 0) exactly when input N-1 is owned and its registered level is 0. Otherwise the line is released.
- R4: In a recovery phase the agent drives high (output-enable 1, value 1) only if it drove low in the sample phase just before. In every turn-around phase it releases the line.
- R5: Frame 1 (input bit 0) is never driven. Inputs outside the ownership mask are never driven, and changes on them never start a cycle.
- R6: The low width of each stop pulse sets the mode of the next cycle: exactly 2 clocks selects quiet mode, and 3 or more selects continuous mode. The mode changes only at the clock that ends a stop pulse.
- R7: In quiet mode, while the agent is idle, a change on an owned input that could not be reported is acted on as follows. The change is registered at the next clock edge, and one clock later the agent drives the line low for exactly one clock.
- R8: A change that is registered during a start pulse, or during the data frames no later than the sample clock of its own frame, does not cause a self-started cycle once the current cycle ends.
- R9: Slot reporting in a cycle the agent started itself follows the same timing and values as in a cycle the host started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_lvl_i | input | NF | Interrupt levels, bit N-1 reported in frame N; a 0 is driven low in its slot |
| sirq_i | input | 1 | Resolved value of the serial line, including the agent's own drive |
| sirq_oe_o | output | 1 | Output-enable for the line driver |
| sirq_o_o | output | 1 | Value driven while the output-enable is high |

## Verification
The assertions assume that `sirq_i` is the resolved line, including the agent's own drive. So when the agent pulls the line low for a self start, the same clock sees a low line and the agent leaves its idle state. They also assume the host drives nothing during data frames and forms stop pulses at least two clocks wide. The bench models the wire as pulled up, overridden by the host's low drive and otherwise by the agent's enabled value. It drives the host only during start and stop pulses and changes the interrupt levels at chosen clocks relative to the frame count.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_START     = 3'd1,
    ST_DATA      = 3'd2,
    ST_STOP_WAIT = 3'd3,
    ST_STOP      = 3'd4
  } sirq_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } sirq_phase_e;

  // Clock (counted from the rising edge of the start pulse) of frame f's sample phase.
  function automatic int unsigned sample_clk(input int unsigned frame);
    return 3 * frame - 1;
  endfunction

  // Clock of the final turn-around phase for nframes frames.
  function automatic int unsigned last_clk(input int unsigned nframes);
    return 3 * nframes + 1;
  endfunction

  // Phase of a given clock count inside the data frames.
  function automatic sirq_phase_e phase_of(input int unsigned c);
    case (c % 3)
      2:       return PH_SAMPLE;
      0:       return PH_RECOVER;
      default: return PH_TURN;
    endcase
  endfunction

endpackage

// File: rtl/sirq_frame_tracker.sv
`timescale 1ns/1ps
module sirq_frame_tracker
  import sirq_pkg::*;
#(
  parameter int NF      = 16,
  parameter int CNT_W   = 6,
  parameter int QUIET_W = 2,
  parameter int WID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output sirq_state_e       state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              quiet_o,
  output logic              start_entry_o,
  output logic              stop_end_o
);

  localparam int unsigned LAST = last_clk(NF);

  sirq_state_e        st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WID_W-1:0]   wid_q;
  logic               quiet_q;

  assign state_o       = st_q;
  assign cnt_o         = cnt_q;
  assign quiet_o       = quiet_q;
  assign start_entry_o = (st_q == ST_IDLE) && !line_i;
  assign stop_end_o    = (st_q == ST_STOP) && line_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wid_q   <= '0;
      quiet_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (!line_i) st_q <= ST_START;
        end
        ST_START: begin
          if (line_i) begin
            st_q  <= ST_DATA;
            cnt_q <= CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (cnt_q == CNT_W'(LAST)) begin
            st_q  <= ST_STOP_WAIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP_WAIT: begin
          if (!line_i) begin
            st_q  <= ST_STOP;
            wid_q <= WID_W'(1);
          end
        end
        ST_STOP: begin
          if (line_i) begin
            st_q    <= ST_IDLE;
            quiet_q <= (wid_q == WID_W'(QUIET_W));
          end else if (wid_q != '1) begin
            wid_q <= wid_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2: the count starts at 1 on the clock after the start pulse rises
  a_r2_count_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && line_i) |=> (st_q == ST_DATA && cnt_q == CNT_W'(1)));

  // R2: data frames always end in the stop search after the final turn-around
  a_r2_frames_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && cnt_q == CNT_W'(LAST)) |=> (st_q == ST_STOP_WAIT));

endmodule

// File: rtl/sirq_req_latch.sv
`timescale 1ns/1ps
module sirq_req_latch
  import sirq_pkg::*;
#(
  parameter int             NF    = 16,
  parameter int             CNT_W = 6,
  parameter logic [NF-1:0]  OWN   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NF-1:0]     req_i,
  input  sirq_state_e       state_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              line_i,
  input  logic              clear_i,
  output logic [NF-1:0]     lvl_o,
  output logic              pending_o
);

  logic [NF-1:0] cur_q;
  logic [NF-1:0] prv_q;
  logic [NF-1:0] dlv;
  logic [NF-1:0] chg;
  logic          pend_q;

  // A change is still deliverable while its frame's sample clock lies ahead.
  for (genvar n = 0; n < NF; n++) begin : g_dlv
    localparam int unsigned SC = sample_clk(n + 1);
    assign dlv[n] = (state_i == ST_START)
                 || (state_i == ST_IDLE && !line_i)
                 || (state_i == ST_DATA && cnt_i <= CNT_W'(SC));
  end

  assign chg       = (cur_q ^ prv_q) & OWN & ~dlv;
  assign lvl_o     = cur_q;
  assign pending_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '1;
      prv_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      cur_q <= req_i;
      prv_q <= cur_q;
      if (|chg)        pend_q <= 1'b1;
      else if (clear_i) pend_q <= 1'b0;
    end
  end

  // R8: nothing becomes pending while a start pulse is on the line
  a_r8_start_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_START && !pend_q) |=> !pend_q);

endmodule

// File: rtl/sirq_slot_driver.sv
`timescale 1ns/1ps
module sirq_slot_driver
  import sirq_pkg::*;
#(
  parameter int             NF    = 16,
  parameter int             CNT_W = 6,
  parameter logic [NF-1:0]  OWN   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sirq_state_e       state_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [NF-1:0]     lvl_i,
  input  logic              quiet_i,
  input  logic              pending_i,
  output logic              oe_o,
  output logic              o_o,
  output logic              self_start_o
);

  localparam logic [NF-1:0] OWN_EFF = OWN & ~NF'(1);

  logic          in_data;
  logic [NF-1:0] hit;
  sirq_phase_e   ph;
  logic          sample_ev;
  logic          drive_low;
  logic          rec_ev;
  logic          turn_ev;
  logic          drove_q;

  assign in_data = (state_i == ST_DATA);

  for (genvar f = 1; f <= NF; f++) begin : g_slot
    localparam int unsigned SC = sample_clk(f);
    assign hit[f-1] = in_data && (cnt_i == CNT_W'(SC));
  end

  assign ph           = phase_of(32'(cnt_i));
  assign sample_ev    = |hit;
  assign drive_low    = |(hit & ~lvl_i & OWN_EFF);
  assign rec_ev       = in_data && (ph == PH_RECOVER) && (cnt_i >= CNT_W'(3));
  assign turn_ev      = in_data && (ph == PH_TURN);
  assign self_start_o = (state_i == ST_IDLE) && quiet_i && pending_i;

  assign oe_o = drive_low | (rec_ev & drove_q) | self_start_o;
  assign o_o  = rec_ev & drove_q;

  always_ff @(posedge clk) begin
    if (!rst_n) drove_q <= 1'b0;
    else        drove_q <= drive_low;
  end

  // R4: a low sample is always followed by a high recovery clock
  a_r4_recover_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ev && oe_o) |=> (oe_o && o_o));

  // R4: high drive only right after a low drive
  a_r4_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && o_o) |-> $past(oe_o && !o_o));

  // R4: turn-around always releases
  a_r4_turn_release: assert property (@(posedge clk) disable iff (!rst_n)
    turn_ev |-> !oe_o);

  // R5: frame 1 is never driven
  a_r5_frame1_silent: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> !oe_o);

  // R1: continuous mode idle never drives
  a_r1_cont_passive: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_IDLE && !quiet_i) |-> !oe_o);

endmodule

// File: rtl/sirq_agent.sv
`timescale 1ns/1ps
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int             NF       = 16,
  parameter logic [NF-1:0]  OWN_MASK = {{(NF-1){1'b1}}, 1'b0},
  parameter int             QUIET_W  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NF-1:0]  req_lvl_i,
  input  logic           sirq_i,
  output logic           sirq_oe_o,
  output logic           sirq_o_o
);

  localparam int CNT_W = $clog2(last_clk(NF) + 1);

  sirq_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic              quiet;
  logic              start_entry;
  logic              stop_end;
  logic [NF-1:0]     lvl;
  logic              pending;
  logic              self_start;

  sirq_frame_tracker #(
    .NF(NF), .CNT_W(CNT_W), .QUIET_W(QUIET_W), .WID_W(3)
  ) trk_i (
    .clk(clk), .rst_n(rst_n), .line_i(sirq_i),
    .state_o(state), .cnt_o(cnt), .quiet_o(quiet),
    .start_entry_o(start_entry), .stop_end_o(stop_end)
  );

  sirq_req_latch #(
    .NF(NF), .CNT_W(CNT_W), .OWN(OWN_MASK)
  ) lat_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_lvl_i),
    .state_i(state), .cnt_i(cnt), .line_i(sirq_i),
    .clear_i(start_entry), .lvl_o(lvl), .pending_o(pending)
  );

  sirq_slot_driver #(
    .NF(NF), .CNT_W(CNT_W), .OWN(OWN_MASK)
  ) drv_i (
    .clk(clk), .rst_n(rst_n), .state_i(state), .cnt_i(cnt),
    .lvl_i(lvl), .quiet_i(quiet), .pending_i(pending),
    .oe_o(sirq_oe_o), .o_o(sirq_o_o), .self_start_o(self_start)
  );

  // R6: the mode changes only at the end of a stop pulse
  a_r6_mode_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quiet) |-> $past(stop_end));

  // R7: a self start lasts one clock
  a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    self_start |=> !self_start);

  // R7: a self start pulls the line low
  a_r7_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    self_start |-> (sirq_oe_o && !sirq_o_o));

endmodule

// File: tb/sirq_agent_tb.sv
`timescale 1ns/1ps
module sirq_agent_tb_top;

  localparam int            NF  = 16;
  localparam logic [15:0]   OWN = 16'hFFFE;
  localparam int            NOCHG = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = 16'hFFFF;
  logic        host_low = 1'b0;
  logic        sirq_oe;
  logic        sirq_o;
  logic        line;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  assign line = host_low ? 1'b0 : (sirq_oe ? sirq_o : 1'b1);

  sirq_agent #(.NF(NF), .OWN_MASK(OWN), .QUIET_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_lvl_i(req), .sirq_i(line),
    .sirq_oe_o(sirq_oe), .sirq_o_o(sirq_o)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {oe,o} act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic slot_low(input int f, input logic [15:0] pat);
    if (f < 2 || f > NF) return 1'b0;
    return OWN[f-1] && !pat[f-1];
  endfunction

  // Called right after the negedge where the start pulse was released (clock 0).
  task automatic run_frames(input logic [15:0] p0, input int chg_k, input logic [15:0] p1);
    for (int k = 0; k <= 3 * NF + 1; k++) begin
      logic [15:0] pat;
      logic [15:0] patp;
      logic d;
      if (k > 0) @(negedge clk);
      if (k == chg_k) req = p1;
      #2;
      pat  = (k > chg_k) ? p1 : p0;
      patp = (k - 1 > chg_k) ? p1 : p0;
      if (k >= 2 && k % 3 == 2) begin
        d = slot_low((k + 1) / 3, pat);
        if ((k + 1) / 3 == 1) chk("R5 frame1", {sirq_oe, sirq_o}, 2'b00);
        else chk("R3 sample", {sirq_oe, sirq_o}, {d, 1'b0});
      end else if (k >= 3 && k % 3 == 0) begin
        d = slot_low(k / 3, patp);
        chk("R4 recovery", {sirq_oe, sirq_o}, {d, d});
      end else begin
        chk("R2 R4 turnaround", {sirq_oe, sirq_o}, 2'b00);
      end
    end
  endtask

  task automatic host_start(input int w, input logic [15:0] pat);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      host_low = 1'b1;
      if (i == 0) req = pat;
    end
    @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic host_stop(input int w);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      host_low = 1'b1;
    end
    @(negedge clk);
    host_low = 1'b0;
    #2 chk("R6 stop end", {sirq_oe, sirq_o}, 2'b00);
  endtask

  task automatic idle_quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2 chk(tag, {sirq_oe, sirq_o}, 2'b00);
    end
  endtask

  task automatic expect_self_start();
    @(negedge clk);
    #2 chk("R7 self start low", {sirq_oe, sirq_o}, 2'b10);
  endtask

  task automatic host_extend(input int w, input logic [15:0] pat);
    @(negedge clk);
    host_low = 1'b1;
    #2 chk("R7 one clock only", {sirq_oe, sirq_o}, 2'b00);
    for (int i = 0; i < w - 2; i++) begin
      @(negedge clk);
      host_low = 1'b1;
    end
    @(negedge clk);
    host_low = 1'b0;
    run_frames(pat, NOCHG, pat); // R9
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] p;
    repeat (3) @(negedge clk);
    #2 chk("R1 reset", {sirq_oe, sirq_o}, 2'b00);
    rst_n = 1'b1;
    // R1: continuous after reset, changes never start a cycle
    @(negedge clk);
    req = 16'hFFF7;
    idle_quiet(6, "R1 continuous idle");

    // R2 R3 R4: host cycles with varying start widths and patterns
    host_start(4, 16'h0000);
    run_frames(16'h0000, NOCHG, 16'h0000);
    host_stop(3);
    req = 16'h1234;
    idle_quiet(5, "R1 R6 continuous after wide stop");
    for (int w = 4; w <= 8; w++) begin
      p = 16'hA5C3 ^ (16'(w) * 16'h1111);
      host_start(w, p);
      run_frames(p, NOCHG, p);
      host_stop(3);
    end
    // R5: walking zero over every frame
    for (int b = 0; b < NF; b++) begin
      p = ~(16'h0001 << b);
      host_start(5, p);
      run_frames(p, NOCHG, p);
      host_stop(3);
    end

    // R6: two-clock stop selects quiet mode
    p = 16'hF0F0;
    host_start(4, p);
    run_frames(p, NOCHG, p);
    host_stop(2);
    idle_quiet(4, "R8 quiet no change");
    @(negedge clk);
    req = p ^ 16'h0001;
    #2 chk("R5 unowned change", {sirq_oe, sirq_o}, 2'b00);
    idle_quiet(4, "R5 unowned change");
    // R7: owned change in quiet idle
    @(negedge clk);
    p = p ^ 16'h0081;
    req = p;
    @(negedge clk);
    #2 chk("R7 not yet", {sirq_oe, sirq_o}, 2'b00);
    expect_self_start();
    host_extend(4, p);
    host_stop(2);

    // R8: change still deliverable in its own slot
    p = 16'h3C3C;
    host_start(4, p);
    run_frames(p, 5, p ^ 16'h8000);
    host_stop(2);
    idle_quiet(6, "R8 delivered change");

    // R7: change after its slot forces a self start after the stop pulse
    p = 16'h5555;
    host_start(4, p);
    run_frames(p, 10, p ^ 16'h0002);
    host_stop(2);
    expect_self_start();
    host_extend(6, p ^ 16'h0002);
    host_stop(3);
    @(negedge clk);
    req = 16'h0F0F;
    idle_quiet(6, "R1 R6 back to continuous");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule